// File: doc/BRIEF.md
# Pipelined Burst Static RAM Model

This block is a synthesizable, cycle-accurate model of a single-port synchronous static RAM. It stores 18-bit words arranged as two 9-bit lanes, each lane being one data byte plus its parity bit. All control inputs are sampled on the rising clock edge, and only on edges where the active-low clock enable is asserted. When the clock enable is high, the edge is skipped. Every pipeline register, the burst state and the output data then hold their values, so a stalled cycle simply stretches the one before it.

Each access starts with a load cycle, which captures a full address together with the read or write direction. Up to three further beats can follow, each produced by an advance cycle. A two-bit counter steps through the four words of the aligned group. It walks the group in either linear order or interleaved order, depending on a static strap input.

Reads and writes use the same timing. A command captured on enabled edge k owns the data slot that runs from enabled edge k+2 to edge k+3. During that slot, read data is driven, or write data is sampled at its closing edge. Because both directions share this alignment, reads and writes can alternate with no dead cycle between them. The data bus is modelled as separate input, output and drive-enable ports. A sleep input freezes all activity while keeping the stored contents.

Top module: `burst_sram`

## Requirements
- R1: On a rising edge where `clkEnN` is high, no command is captured, no write is performed and `dataOut`/`dataOe` keep the value they had, apart from the asynchronous effect of `outEnN` and `doze`.
- R2: A load cycle (`burstStep` low) starts an access only when `ce1N`=0, `ce2`=1 and `ce3N`=0; any other combination is a deselect cycle with no access.
- R3: An advance cycle (`burstStep` high) continues the current access with its original direction, ignoring chip enables and `weN`; after a deselect or sleep edge, advance cycles perform no access until the next load.
- R4: With `interleave` low, the beat offset placed on address bits [1:0] after n advances is (start + n) mod 4, with the upper address bits kept from the load address.
- R5: With `interleave` high, the beat offset is start XOR n (n = 0..3), with the upper address bits kept from the load address.
- R6: Read data for a command captured on enabled edge k is driven on `dataOut` after enabled edge k+2 and held until enabled edge k+3.
- R7: A write command captured on enabled edge k stores the value on `dataIn` sampled at enabled edge k+3, which is at the end of the same slot in which a read would be driven.
- R8: `byteWeN[0]` low enables writing of lane 0 (`dataIn[8:0]`, byte plus parity). `byteWeN[1]` low enables writing of lane 1 (`dataIn[17:9]`). A lane whose enable is high keeps its old contents. The enables are sampled with every beat.
- R9: `dataOe` is high only while the current slot belongs to a read, `outEnN` is low and `doze` is low. Write, deselect and post-deselect slots never drive.
- R10: While `doze` is high, `dataOe` is low, commands sampled on enabled edges are discarded, a write whose slot closes on that edge is dropped and stored data is preserved.
- R11: A read captured one enabled edge after a write to the same address returns the newly written lanes. The read's data is taken in the same edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset of pipeline and burst state (contents untouched) |
| clkEnN | input | 1 | Active-low clock enable; high skips the edge |
| addr | input | ADDR_W | Word address, captured on load cycles |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| weN | input | 1 | Low on a load cycle selects write |
| byteWeN | input | 2 | Active-low lane write enables, one per 9-bit lane |
| burstStep | input | 1 | Low loads a new address, high advances the burst |
| interleave | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| outEnN | input | 1 | Asynchronous active-low output enable |
| doze | input | 1 | Sleep request, active high |
| dataIn | input | 18 | Write data from the bus |
| dataOut | output | 18 | Read data to the bus |
| dataOe | output | 1 | Bus drive enable |

## Verification
Two cases are the sharpest. The first is a write that completes on the same edge that captures read data for the next command to the same word. The second is a stall landing in the middle of a burst, which must freeze both the beat counter and the data slot in flight. The bench provokes both through long random command streams. These streams mix loads, advances, deselects, stalls, lane masks, output-enable toggles and sleep pulses, and are run in both burst orders. Directed bursts from every start offset are added, along with write-then-read pairs to one address. Every cycle is judged against a behavioural model in the bench that keeps a short history of accepted commands and a reference array. That model predicts both the drive enable and the driven word.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef struct packed {
    logic             advance;   // enabled edge this cycle
    logic             rdEn;      // a read enters its data slot on the next enabled edge
    logic             wrEn;      // the write slot closes on this edge
    logic [LANES-1:0] wrLaneEn;  // active-high lane enables for wrEn
    logic             slotRead;  // current slot belongs to a read
  } strobe_t;
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              weN,
  input  logic [LANES-1:0]  byteWeN,
  input  logic              burstStep,
  input  logic              interleave,
  input  logic              doze,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr
);
  localparam int STAGES = 3;
  localparam int RD_STG = 1;
  localparam int WR_STG = STAGES - 1;

  logic              selected;
  logic              advance;
  logic              cmdValid;
  logic              cmdWrite;
  logic [ADDR_W-1:0] cmdAddr;
  logic              burstLive;
  logic              burstWr;
  logic [ADDR_W-1:0] burstBase;
  logic [1:0]        burstCnt;
  logic [1:0]        nextCnt;
  logic [1:0]        nextOff;

  logic              pV [STAGES];
  logic              pW [STAGES];
  logic [ADDR_W-1:0] pA [STAGES];
  logic [LANES-1:0]  pB [STAGES];

  assign selected = !ce1N && ce2 && !ce3N;
  assign advance  = !clkEnN;
  assign nextCnt  = burstCnt + 2'd1;
  assign nextOff  = interleave ? (burstBase[1:0] ^ nextCnt)
                               : (burstBase[1:0] + nextCnt);

  // Command formed from this cycle's inputs
  always_comb begin
    cmdValid = 1'b0;
    cmdWrite = 1'b0;
    cmdAddr  = addr;
    if (!doze) begin
      if (!burstStep) begin
        cmdValid = selected;
        cmdWrite = !weN;
      end else begin
        cmdValid = burstLive;
        cmdWrite = burstWr;
        cmdAddr  = {burstBase[ADDR_W-1:2], nextOff};
      end
    end
  end

  // Burst counter state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstLive <= 1'b0;
      burstWr   <= 1'b0;
      burstBase <= '0;
      burstCnt  <= '0;
    end else if (advance) begin
      if (doze) begin
        burstLive <= 1'b0;
      end else if (!burstStep) begin
        burstLive <= selected;
        burstWr   <= !weN;
        burstBase <= addr;
        burstCnt  <= '0;
      end else if (burstLive) begin
        burstCnt  <= nextCnt;
      end
    end
  end

  // Command pipeline: stage 0 captured now, RD_STG feeds read, WR_STG owns slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) begin
        pV[i] <= 1'b0;
        pW[i] <= 1'b0;
        pA[i] <= '0;
        pB[i] <= '1;
      end
    end else if (advance) begin
      pV[0] <= cmdValid;
      pW[0] <= cmdWrite;
      pA[0] <= cmdAddr;
      pB[0] <= byteWeN;
      for (int i = 1; i < STAGES; i++) begin
        pV[i] <= pV[i-1];
        pW[i] <= pW[i-1];
        pA[i] <= pA[i-1];
        pB[i] <= pB[i-1];
      end
    end
  end

  assign strb.advance  = advance;
  assign strb.rdEn     = pV[RD_STG] && !pW[RD_STG];
  assign strb.wrEn     = advance && !doze && pV[WR_STG] && pW[WR_STG];
  assign strb.wrLaneEn = ~pB[WR_STG];
  assign strb.slotRead = pV[WR_STG] && !pW[WR_STG];
  assign rdAddr        = pA[RD_STG];
  assign wrAddr        = pA[WR_STG];

  // R1: a skipped edge leaves the captured command untouched
  a_r1_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(pV[0]) && $stable(pA[0]) && $stable(pV[WR_STG])));

  // R2: a load with a failing chip-enable combination captures no access
  a_r2_deselect: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !burstStep && (ce1N || !ce2 || ce3N)) |=> !pV[0]);

  // R3: advancing with no live burst captures nothing
  a_r3_no_orphan_advance: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && burstStep && !burstLive) |=> !pV[0]);

  // R4: linear advance steps the offset by one
  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && burstStep && burstLive && !interleave && !doze)
      |=> (pA[0][1:0] == $past(pA[0][1:0]) + 2'd1));

  // R5: any advance keeps the upper address bits of the burst
  a_r5_group_kept: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && burstStep && burstLive && !doze)
      |=> (pA[0][ADDR_W-1:2] == $past(pA[0][ADDR_W-1:2])));

  // R6: a read in the read stage owns the slot after the next enabled edge
  a_r6_read_slot: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && pV[RD_STG] && !pW[RD_STG]) |=> strb.slotRead);
endmodule

// File: rtl/bsram_datapath.sv
module bsram_datapath
  import bsram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] dataOut
);
  logic [WORD_W-1:0] fwdWord;
  logic [WORD_W-1:0] outReg;
  logic              sameWord;

  assign sameWord = strb.wrEn && (wrAddr == rdAddr);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneRd;
    logic [LANE_W-1:0] laneWr;

    assign laneRd = laneMem[rdAddr];
    assign laneWr = dataIn[g*LANE_W +: LANE_W];
    assign fwdWord[g*LANE_W +: LANE_W] =
      (sameWord && strb.wrLaneEn[g]) ? laneWr : laneRd;

    always_ff @(posedge clk) begin
      if (strb.wrEn && strb.wrLaneEn[g]) laneMem[wrAddr] <= laneWr;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.advance && strb.rdEn) outReg <= fwdWord;
  end

  assign dataOut = outReg;

  // R11: a full-word write and a read of the same word on one edge forward the new data
  a_r11_forward: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && strb.rdEn && sameWord && (&strb.wrLaneEn))
      |=> (dataOut == $past(dataIn)));
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              weN,
  input  logic [LANES-1:0]  byteWeN,
  input  logic              burstStep,
  input  logic              interleave,
  input  logic              outEnN,
  input  logic              doze,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOe
);
  strobe_t           strb;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] wrAddr;

  bsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rstN, .clkEnN, .addr, .ce1N, .ce2, .ce3N, .weN, .byteWeN,
    .burstStep, .interleave, .doze, .strb, .rdAddr, .wrAddr
  );

  bsram_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_data (
    .clk, .rstN, .strb, .rdAddr, .wrAddr, .dataIn, .dataOut
  );

  assign dataOe = strb.slotRead && !outEnN && !doze;

  // R9: a write slot never drives the bus
  a_r9_write_slot_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> !dataOe);

  // R10: sleep keeps the bus released
  a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (doze && $past(doze)) |-> !dataOe);
endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  localparam int DEPTH = 1024;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0, clkEnN = 1'b0, ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1, weN = 1'b1;
  logic [1:0] byteWeN = 2'b11;
  logic burstStep = 1'b0, interleave = 1'b0, outEnN = 1'b0, doze = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [17:0] dataIn = '0;
  logic [17:0] dataOut;
  logic dataOe;

  always #5 clk = ~clk;

  burst_sram #(.DEPTH(DEPTH)) u_dut (
    .clk, .rstN, .clkEnN, .addr, .ce1N, .ce2, .ce3N, .weN, .byteWeN,
    .burstStep, .interleave, .outEnN, .doze, .dataIn, .dataOut, .dataOe
  );

  typedef struct { bit v; bit w; int a; bit [1:0] bw; } cmd_s;
  cmd_s hist[$];
  logic [17:0] refMem [DEPTH];
  bit   expRead;
  logic [17:0] expData;
  bit   mLive, mW;
  int   mBaseHi, mStart, mN;
  int   nVec = 0, nBad = 0;
  string tag = "R9";
  bit   finished = 1'b0;

  task automatic modelReset();
    hist.delete();
    for (int i = 0; i < 3; i++) hist.push_back('{0, 0, 0, 2'b11});
    expRead = 0; mLive = 0; mW = 0; mBaseHi = 0; mStart = 0; mN = 0;
  endtask

  task automatic modelEdge();
    cmd_s nc;
    cmd_s old;
    bit sel;
    int off;
    nc = '{0, 0, 0, 2'b11};
    old = hist[2];
    if (!doze && old.v && old.w) begin              // R7, R8
      if (!old.bw[0]) refMem[old.a][8:0]  = dataIn[8:0];
      if (!old.bw[1]) refMem[old.a][17:9] = dataIn[17:9];
    end
    expRead = hist[1].v && !hist[1].w;             // R6, R11
    if (expRead) expData = refMem[hist[1].a];
    if (doze) mLive = 0;                            // R10
    else if (!burstStep) begin                      // R2
      sel = !ce1N && ce2 && !ce3N;
      mLive = sel; mW = !weN; mStart = int'(addr) % 4;
      mBaseHi = int'(addr) - mStart; mN = 0;
      nc = '{sel, !weN, int'(addr), byteWeN};
    end else if (mLive) begin                       // R3, R4, R5
      mN = (mN + 1) % 4;
      off = interleave ? (mStart ^ mN) : ((mStart + mN) % 4);
      nc = '{1, mW, mBaseHi + off, byteWeN};
    end
    hist.push_front(nc);
    void'(hist.pop_back());
  endtask

  task automatic compare();
    bit eo;
    eo = rstN && expRead && !outEnN && !doze;
    nVec++;
    if (dataOe !== eo) begin
      nBad++;
      $display("FAIL %s dataOe actual=%b expected=%b t=%0t", tag, dataOe, eo, $time);
    end else if (eo && dataOut !== expData) begin
      nBad++;
      $display("FAIL %s dataOut actual=%h expected=%h t=%0t", tag, dataOut, expData, $time);
    end
  endtask

  // One clock: inputs already set at the falling edge
  task automatic cyc();
    dataIn = 18'($urandom);
    @(posedge clk);
    if (!rstN) modelReset();
    else if (!clkEnN) modelEdge();
    #2;
    compare();
    @(negedge clk);
  endtask

  task automatic load(input int a, input bit w, input bit [1:0] bw);
    clkEnN = 0; burstStep = 0; ce1N = 0; ce2 = 1; ce3N = 0;
    weN = !w; addr = AW'(a); byteWeN = bw; cyc();
  endtask

  task automatic adv(input bit [1:0] bw);
    clkEnN = 0; burstStep = 1; byteWeN = bw; weN = 1; ce1N = 1; addr = '0; cyc();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      clkEnN = 0; burstStep = 0; ce1N = 1; ce2 = 0; ce3N = 1; cyc();
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    modelReset();
    @(negedge clk);
    rstN = 0;
    repeat (3) cyc();
    rstN = 1;
    tag = "R9"; idle(2);                       // reset state: bus released

    tag = "R7";                                 // fill every word, back to back
    for (int a = 0; a < DEPTH; a++) load(a, 1, 2'b00);
    idle(3);

    for (int m = 0; m < 2; m++) begin           // bursts from every offset, both orders
      interleave = m[0];
      tag = m ? "R5" : "R4";
      for (int s = 0; s < 4; s++) begin
        for (int w = 0; w < 2; w++) begin
          int base;
          base = (int'($urandom) % DEPTH) & ~3 | s;
          load(base, w[0], w ? 2'($urandom) : 2'b11);
          for (int b = 0; b < 3; b++) adv(w ? 2'($urandom) : 2'b11);
          idle(1);
          tag = "R8";
          load(base & ~3, 0, 2'b11);
          for (int b = 0; b < 3; b++) adv(2'b11);
          idle(3);
          tag = m ? "R5" : "R4";
        end
      end
    end
    interleave = 0;

    tag = "R3";                                 // advance after deselect
    load(12, 0, 2'b11); idle(1);
    for (int b = 0; b < 3; b++) adv(2'b11);
    idle(3);

    tag = "R2";                                 // every chip-enable combination
    for (int c = 0; c < 8; c++) begin
      clkEnN = 0; burstStep = 0; weN = 0; byteWeN = 2'b00;
      ce1N = c[0]; ce2 = c[1]; ce3N = c[2]; addr = AW'(40 + c); cyc();
      load(40 + c, 0, 2'b11);
      idle(3);
    end

    tag = "R11";                                // write then read of one word
    for (int k = 0; k < 8; k++) begin
      load(100 + k, 1, 2'(k));
      load(100 + k, 0, 2'b11);
      idle(3);
    end

    tag = "R1";                                 // stalls in a burst
    load(200, 0, 2'b11);
    clkEnN = 1; cyc(); cyc();
    adv(2'b11);
    clkEnN = 1; cyc();
    adv(2'b11); clkEnN = 1; cyc(); cyc(); adv(2'b11);
    idle(3);

    tag = "R9";                                 // output enable toggled in a read slot
    load(300, 0, 2'b11); adv(2'b11); adv(2'b11); adv(2'b11);
    outEnN = 1; idle(1); outEnN = 0; idle(1); outEnN = 1; idle(1); outEnN = 0;
    idle(2);

    tag = "R10";                                // sleep across a write slot
    load(400, 1, 2'b00); load(401, 1, 2'b00); load(400, 0, 2'b11);
    doze = 1; idle(1); doze = 0;
    load(400, 0, 2'b11); load(401, 0, 2'b11);
    doze = 1; idle(2); doze = 0;
    idle(3);

    tag = "R6";                                 // long random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      interleave = (i >= 2000);
      r = int'($urandom % 100);
      clkEnN = (r < 15);
      burstStep = ($urandom % 3 == 0);
      ce1N = ($urandom % 8 == 0); ce2 = ($urandom % 8 != 0); ce3N = ($urandom % 8 == 0);
      weN = $urandom % 2;
      byteWeN = 2'($urandom);
      addr = AW'($urandom);
      outEnN = ($urandom % 10 == 0);
      doze = ($urandom % 40 == 0);
      cyc();
    end
    doze = 0; outEnN = 0;
    idle(3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule